// File: doc/BRIEF.md
# Segment Limit Check Unit

This block decides whether a memory access lies inside the valid offset window of a segment. It receives the raw 20-bit limit field of a segment descriptor together with three qualifier bits. The granularity bit selects byte or 4 KiB units. The expand-down bit selects a reversed window and takes effect only for data segments. The big bit selects the upper bound of an expand-down window. The block also takes the access offset and the access size.

From these inputs the block forms the 32-bit effective limit. It then tests the first and the last byte touched by the access against the window. A carry out of the 32-bit offset sum counts as leaving the window.

The caller pulses a request strobe with stable inputs. One clock later the block raises a one-cycle completion pulse. At the same moment it presents a registered general-protection fault flag and the effective limit. Both outputs hold their values until the next request. Fetching descriptors, decoding the descriptor type and delivering the exception are left to the surrounding logic.

Top module: `seg_limit_check`

## Requirements
- R1: With granularity bit 0, the effective limit equals the 20-bit field zero-extended to 32 bits.
- R2: With granularity bit 1, the effective limit equals the field shifted left by 12, with the low 12 bits all ones.
- R3: For a normal segment, a fault is raised exactly when the last byte touched exceeds the effective limit. The last byte touched is offset + bytes − 1. The size code gives the byte count: 2'b00 is 1 byte, 2'b01 is 2 bytes, 2'b10 is 4 bytes, and 2'b11 is also taken as 4 bytes.
- R4: For a normal segment, an access whose last byte wraps past 0xFFFFFFFF faults.
- R5: For an expand-down segment, any offset less than or equal to the effective limit faults. A segment is expand-down when both the expand-down bit and the data-segment input are 1.
- R6: For an expand-down segment, the last byte touched must not exceed the upper bound. The bound is 0xFFFF when the big bit is 0 and 0xFFFFFFFF when it is 1. A last byte that wraps past 32 bits faults.
- R7: An expand-down segment with a limit of zero accepts every offset from 1 up to its upper bound. Only offset 0 faults.
- R8: When the data-segment input is 0, the expand-down bit has no effect and the segment is checked as normal.
- R9: A request strobe in one cycle produces a one-cycle done pulse in the next. The fault flag and the effective limit update in that same cycle and hold their values while no request is made.
- R10: While reset is asserted and until the first request, done, fault and the effective limit are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, inputs sampled in this cycle |
| limitRaw | input | 20 | Raw descriptor limit field |
| granBit | input | 1 | 1 = limit counted in 4 KiB units |
| expDown | input | 1 | Expand-down window select |
| bigBit | input | 1 | Expand-down upper bound select |
| dataSeg | input | 1 | Segment is a data segment |
| offset | input | 32 | Access offset |
| accSize | input | 2 | Access size code |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Registered general-protection fault flag |
| effLimit | output | 32 | Registered effective limit |

## Verification
A wrong span decode or a lost carry in the last-byte sum shows up as a wrong fault flag. It appears one cycle after the offending request, and only near a window edge. For that reason the vectors sit on both sides of every boundary and at the 32-bit wrap. A broken capture strobe shows in two ways. The done pulse may be missing or may stretch. The outputs may change while no request is pending. Both effects are visible on the cycle after the strobe.

// File: rtl/seg_limit_pkg.sv
package seg_limit_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_WORD  = 2'b01,
    SZ_DWORD = 2'b10,
    SZ_WIDE  = 2'b11
  } accSize_e;

  typedef struct packed {
    logic capture;
  } ctrlStrobe_t;

endpackage

// File: rtl/seg_limit_ctrl.sv
module seg_limit_ctrl
  import seg_limit_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output ctrlStrobe_t strobe,
  output logic        done
);

  always_comb begin
    strobe.capture = reqValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) done <= 1'b0;
    else       done <= reqValid;
  end

endmodule

// File: rtl/seg_limit_dp.sv
module seg_limit_dp
  import seg_limit_pkg::*;
#(
  parameter int LIMIT_W    = 20,
  parameter int GRAN_SHIFT = 12,
  parameter int SMALL_W    = 16,
  parameter int ADDR_W     = LIMIT_W + GRAN_SHIFT
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobe,
  input  logic [LIMIT_W-1:0] limitRaw,
  input  logic               granBit,
  input  logic               expDown,
  input  logic               bigBit,
  input  logic               dataSeg,
  input  logic [ADDR_W-1:0]  offset,
  input  logic [1:0]         accSize,
  output logic               fault,
  output logic [ADDR_W-1:0]  effLimit
);

  localparam int SUM_W = ADDR_W + 1;

  logic [ADDR_W-1:0] limitExp;
  logic [ADDR_W-1:0] upperBound;
  logic [ADDR_W-1:0] spanM1;
  logic [SUM_W-1:0]  lastByte;
  logic              downMode;
  logic              faultNext;

  // Limit expansion by granularity
  always_comb begin
    if (granBit) limitExp = {limitRaw, {GRAN_SHIFT{1'b1}}};
    else         limitExp = ADDR_W'(limitRaw);
  end

  // Span minus one from the size code; the spare code counts as four bytes
  always_comb begin
    unique case (accSize_e'(accSize))
      SZ_BYTE: spanM1 = ADDR_W'(0);
      SZ_WORD: spanM1 = ADDR_W'(1);
      default: spanM1 = ADDR_W'(3);
    endcase
  end

  // Carry bit kept so that a wrap past the top counts as out of range
  assign lastByte   = {1'b0, offset} + {1'b0, spanM1};
  assign upperBound = bigBit ? {ADDR_W{1'b1}} : ADDR_W'({SMALL_W{1'b1}});
  assign downMode   = expDown & dataSeg;

  always_comb begin
    if (downMode)
      faultNext = (offset <= limitExp) || (lastByte > {1'b0, upperBound});
    else
      faultNext = lastByte > {1'b0, limitExp};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fault    <= 1'b0;
      effLimit <= '0;
    end else if (strobe.capture) begin
      fault    <= faultNext;
      effLimit <= limitExp;
    end
  end

endmodule

// File: rtl/seg_limit_check.sv
module seg_limit_check #(
  parameter int LIMIT_W    = 20,
  parameter int GRAN_SHIFT = 12,
  parameter int SMALL_W    = 16,
  parameter int ADDR_W     = LIMIT_W + GRAN_SHIFT
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [LIMIT_W-1:0] limitRaw,
  input  logic               granBit,
  input  logic               expDown,
  input  logic               bigBit,
  input  logic               dataSeg,
  input  logic [ADDR_W-1:0]  offset,
  input  logic [1:0]         accSize,
  output logic               done,
  output logic               fault,
  output logic [ADDR_W-1:0]  effLimit
);

  seg_limit_pkg::ctrlStrobe_t strobe;

  seg_limit_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .strobe   (strobe),
    .done     (done)
  );

  seg_limit_dp #(
    .LIMIT_W    (LIMIT_W),
    .GRAN_SHIFT (GRAN_SHIFT),
    .SMALL_W    (SMALL_W),
    .ADDR_W     (ADDR_W)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .limitRaw (limitRaw),
    .granBit  (granBit),
    .expDown  (expDown),
    .bigBit   (bigBit),
    .dataSeg  (dataSeg),
    .offset   (offset),
    .accSize  (accSize),
    .fault    (fault),
    .effLimit (effLimit)
  );

endmodule

// File: rtl/seg_limit_check_sva.sv
module seg_limit_check_sva #(
  parameter int LIMIT_W = 20,
  parameter int ADDR_W  = 32,
  parameter int SMALL_W = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               reqValid,
  input logic [LIMIT_W-1:0] limitRaw,
  input logic               granBit,
  input logic               expDown,
  input logic               bigBit,
  input logic               dataSeg,
  input logic [ADDR_W-1:0]  offset,
  input logic [1:0]         accSize,
  input logic               done,
  input logic               fault,
  input logic [ADDR_W-1:0]  effLimit
);

  assert_low_fill_R2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && granBit |=> effLimit[ADDR_W-LIMIT_W-1:0] == '1);

  assert_zero_ext_R1: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !granBit |=> effLimit[ADDR_W-1:LIMIT_W] == '0);

  assert_byte_normal_R3: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !dataSeg && accSize == 2'b00 |=> fault == ($past(offset) > effLimit));

  assert_small_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && expDown && dataSeg && !bigBit && offset[ADDR_W-1:SMALL_W] != '0 |=> fault);

  assert_zero_limit_R7: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && expDown && dataSeg && bigBit && limitRaw == '0 && !granBit
      && accSize == 2'b00 && offset != '0 |=> !fault);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> done);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !done);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> $stable(fault) && $stable(effLimit));

endmodule

bind seg_limit_check seg_limit_check_sva #(
  .LIMIT_W (LIMIT_W),
  .ADDR_W  (ADDR_W),
  .SMALL_W (SMALL_W)
) chk_i (.*);

// File: tb/seg_limit_check_tb.sv
module seg_limit_check_tb_top;

  typedef struct packed {
    logic [19:0] lim;
    logic        g;
    logic        e;
    logic        b;
    logic        d;
    logic [31:0] off;
    logic [1:0]  sz;
    logic        xf;
    logic [31:0] xl;
  } vec_t;

  localparam int NVEC = 20;

  localparam vec_t VECS [NVEC] = '{
    '{20'h00FFF, 1'b0, 1'b0, 1'b0, 1'b0, 32'h00000FFF, 2'b00, 1'b0, 32'h00000FFF}, // R1 R3 edge
    '{20'h00FFF, 1'b0, 1'b0, 1'b0, 1'b0, 32'h00001000, 2'b00, 1'b1, 32'h00000FFF}, // R3 one past
    '{20'h00FFF, 1'b0, 1'b0, 1'b0, 1'b0, 32'h00000FFE, 2'b01, 1'b0, 32'h00000FFF}, // R3 word fits
    '{20'h00FFF, 1'b0, 1'b0, 1'b0, 1'b0, 32'h00000FFE, 2'b10, 1'b1, 32'h00000FFF}, // R3 dword straddles
    '{20'h00FFF, 1'b0, 1'b0, 1'b0, 1'b0, 32'h00000FFC, 2'b10, 1'b0, 32'h00000FFF}, // R3 dword fits
    '{20'h00001, 1'b1, 1'b0, 1'b0, 1'b0, 32'h00001FFF, 2'b00, 1'b0, 32'h00001FFF}, // R2
    '{20'hFFFFF, 1'b1, 1'b0, 1'b0, 1'b0, 32'hFFFFFFFE, 2'b01, 1'b0, 32'hFFFFFFFF}, // R2 top word
    '{20'hFFFFF, 1'b1, 1'b0, 1'b0, 1'b0, 32'hFFFFFFFE, 2'b10, 1'b1, 32'hFFFFFFFF}, // R4 wrap
    '{20'h00FFF, 1'b0, 1'b1, 1'b0, 1'b1, 32'h00000FFF, 2'b00, 1'b1, 32'h00000FFF}, // R5 at limit
    '{20'h00FFF, 1'b0, 1'b1, 1'b0, 1'b1, 32'h00001000, 2'b00, 1'b0, 32'h00000FFF}, // R5 limit+1
    '{20'h00FFF, 1'b0, 1'b1, 1'b0, 1'b1, 32'h0000FFFF, 2'b00, 1'b0, 32'h00000FFF}, // R6 small top
    '{20'h00FFF, 1'b0, 1'b1, 1'b0, 1'b1, 32'h0000FFFE, 2'b10, 1'b1, 32'h00000FFF}, // R6 past small top
    '{20'h00FFF, 1'b0, 1'b1, 1'b1, 1'b1, 32'h0000FFFE, 2'b10, 1'b0, 32'h00000FFF}, // R6 big bound
    '{20'h00FFF, 1'b0, 1'b1, 1'b1, 1'b1, 32'hFFFFFFFE, 2'b10, 1'b1, 32'h00000FFF}, // R6 wrap
    '{20'h00000, 1'b0, 1'b1, 1'b1, 1'b1, 32'h00000000, 2'b00, 1'b1, 32'h00000000}, // R7 offset 0
    '{20'h00000, 1'b0, 1'b1, 1'b1, 1'b1, 32'h00000001, 2'b00, 1'b0, 32'h00000000}, // R7 offset 1
    '{20'h00000, 1'b0, 1'b1, 1'b1, 1'b1, 32'hFFFFFFFF, 2'b00, 1'b0, 32'h00000000}, // R7 top byte
    '{20'h00FFF, 1'b0, 1'b1, 1'b0, 1'b0, 32'h00000800, 2'b00, 1'b0, 32'h00000FFF}, // R8 inside
    '{20'h00FFF, 1'b0, 1'b1, 1'b0, 1'b0, 32'h00002000, 2'b00, 1'b1, 32'h00000FFF}, // R8 outside
    '{20'h00FFF, 1'b0, 1'b0, 1'b0, 1'b0, 32'h00000FFD, 2'b11, 1'b1, 32'h00000FFF}  // R3 spare size code
  };

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid;
  logic [19:0] limitRaw;
  logic        granBit, expDown, bigBit, dataSeg;
  logic [31:0] offset;
  logic [1:0]  accSize;
  logic        done, fault;
  logic [31:0] effLimit;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  seg_limit_check dut_i (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .limitRaw (limitRaw),
    .granBit  (granBit),
    .expDown  (expDown),
    .bigBit   (bigBit),
    .dataSeg  (dataSeg),
    .offset   (offset),
    .accSize  (accSize),
    .done     (done),
    .fault    (fault),
    .effLimit (effLimit)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v, input logic vld);
    limitRaw = v.lim; granBit = v.g; expDown = v.e; bigBit = v.b;
    dataSeg  = v.d;   offset  = v.off; accSize = v.sz; reqValid = vld;
  endtask

  initial begin
    #1500000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    drive(VECS[0], 1'b1);
    repeat (3) @(negedge clk);
    // R10 reset state, even with a request held during reset
    check(done == 1'b0, "R10 done in reset", 32'(done), 32'd0);
    check(fault == 1'b0, "R10 fault in reset", 32'(fault), 32'd0);
    check(effLimit == 32'd0, "R10 limit in reset", effLimit, 32'd0);
    reqValid = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    check(done == 1'b0 && effLimit == 32'd0, "R10 idle after reset", effLimit, 32'd0);

    for (int i = 0; i < NVEC; i++) begin
      drive(VECS[i], 1'b1);
      @(negedge clk);
      reqValid = 1'b0;
      check(done == 1'b1, $sformatf("R9 done vector %0d", i), 32'(done), 32'd1);
      check(fault == VECS[i].xf, $sformatf("fault vector %0d (tag in table)", i),
            32'(fault), 32'(VECS[i].xf));
      check(effLimit == VECS[i].xl, $sformatf("limit vector %0d (R1/R2 tags)", i),
            effLimit, VECS[i].xl);
    end

    // R9 hold: change inputs with no strobe, outputs keep the last result
    drive(VECS[0], 1'b0);
    @(negedge clk);
    check(done == 1'b0, "R9 done single cycle", 32'(done), 32'd0);
    check(fault == VECS[NVEC-1].xf, "R9 fault held", 32'(fault), 32'(VECS[NVEC-1].xf));
    check(effLimit == VECS[NVEC-1].xl, "R9 limit held", effLimit, VECS[NVEC-1].xl);

    // R9 back-to-back requests give a done on each cycle
    drive(VECS[1], 1'b1);
    @(negedge clk);
    drive(VECS[5], 1'b1);
    check(done && fault == 1'b1, "R9 back-to-back first", 32'(fault), 32'd1);
    @(negedge clk);
    reqValid = 1'b0;
    check(done && fault == 1'b0 && effLimit == 32'h00001FFF, "R9 back-to-back second",
          effLimit, 32'h00001FFF);

    // R8 big bit with no data segment also ignored: normal check at limit+1 faults
    drive('{20'h00FFF, 1'b0, 1'b1, 1'b1, 1'b0, 32'h00001000, 2'b00, 1'b0, 32'h0}, 1'b1);
    @(negedge clk);
    reqValid = 1'b0;
    check(fault == 1'b1, "R8 qualifiers ignored", 32'(fault), 32'd1);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule